// File: doc/BRIEF.md
# Banked RAM Paging Controller

This block sits between an 8-bit CPU and 128 KB of dynamic RAM that is organised as two 64 KB banks. The CPU sees a 64 KB address space divided into four 16 KB windows, selected by its two top address bits. A 3-bit mode value, held in a small register, decides for every access which bank answers and which two physical address bits are presented to that bank.

The CPU changes the mode with an I/O write. The write takes effect only when the top address bits read `01` and data bits 7 and 6 are both high. Data bits 2..0 then become the new mode. The write is recognised on the first clock edge at which the active-low write strobe is low. Holding the strobe low for further cycles does not reload the register.

The incoming active-low column strobe is steered to exactly one of two bank strobes. A RAM-disable input, when high, keeps both bank strobes inactive. The address translation is purely combinational from the stored mode and the current address bits, so a new mapping applies from the cycle after the loading edge.

Top module: `ram_page_ctrl`

## Requirements
- R1: While `rst_n` is low the mode is forced to 0. After reset, every window maps to bank 0 with `phys_addr_hi` equal to `cpu_addr_hi`.
- R2: The mode loads `data_in[2:0]` on a rising clock edge only when all of these hold: `io_wr_n` is low at that edge, `io_wr_n` was high at the previous edge, `cpu_addr_hi` is `2'b01`, and `data_in[7]` and `data_in[6]` are both 1. The new mapping is visible after that edge.
- R3: An I/O write with `cpu_addr_hi` other than `2'b01`, or with either of `data_in[7]` or `data_in[6]` at 0, leaves the mapping unchanged.
- R4: If `io_wr_n` stays low over several edges, only the first of those edges can load. Changes to `data_in` during the remaining low cycles are ignored.
- R5: In modes 0, 1 and 2, `phys_addr_hi` equals `cpu_addr_hi` in every window. Mode 0 selects bank 0 for all windows. Mode 2 selects bank 1 for all windows.
- R6: Mode 1 selects bank 1 only for window 3 (`cpu_addr_hi` = `2'b11`). The other three windows use bank 0.
- R7: Mode 3 maps window 1 to bank 0 with `phys_addr_hi` = `2'b11`, and window 3 to bank 1. Windows 0 and 2 pass through to bank 0.
- R8: In modes 4 to 7, window 1 maps to bank 1 with `phys_addr_hi` equal to the mode's two low bits. The other windows pass through to bank 0.
- R9: Windows 0 and 2 always present `phys_addr_hi` equal to `cpu_addr_hi`. They use bank 0 in every mode except mode 2.
- R10: `bank0_cas_n` and `bank1_cas_n` are never low together. The selected bank's strobe is low exactly when `cas_n` is low and `ram_off` is low.
- R11: While `ram_off` is high or `cas_n` is high, both bank strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; forces mode 0 |
| cpu_addr_hi | input | 2 | CPU address bits 15..14 |
| data_in | input | 8 | CPU data bus |
| io_wr_n | input | 1 | Active-low I/O write strobe |
| cas_n | input | 1 | Active-low column strobe from the DRAM timing logic |
| ram_off | input | 1 | High disables both banks |
| bank0_cas_n | output | 1 | Active-low column strobe to bank 0 |
| bank1_cas_n | output | 1 | Active-low column strobe to bank 1 |
| phys_addr_hi | output | 2 | Physical address bits 15..14 to the RAM |

## Verification
A mode load and a RAM access can occur in the same cycle: the translation is combinational while the register updates on the clock edge. The bench holds `cas_n` low on window 1 and issues a qualified write on that same clock edge. It checks that the bank strobe and `phys_addr_hi` follow the old mode before the edge and the new mode after it, with exactly one bank strobe low on both sides of the edge. A second case holds the write strobe low across several edges while the data changes, and checks that only the first edge loads.

// File: rtl/ram_page_ctrl.sv
module ram_page_ctrl #(
  parameter int MODE_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cpu_addr_hi,
  input  logic [7:0] data_in,
  input  logic       io_wr_n,
  input  logic       cas_n,
  input  logic       ram_off,
  output logic       bank0_cas_n,
  output logic       bank1_cas_n,
  output logic [1:0] phys_addr_hi
);

  logic [MODE_W-1:0] mode;
  logic              wr_n_q;
  logic              hit;
  logic              load;
  logic              use_b1;
  logic              en;

  assign hit  = (cpu_addr_hi == 2'b01) && data_in[7] && data_in[6];
  assign load = !io_wr_n && wr_n_q && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= '0;
      wr_n_q <= 1'b1;
    end else begin
      wr_n_q <= io_wr_n;
      if (load) mode <= data_in[MODE_W-1:0];
    end
  end

  always_comb begin
    use_b1       = 1'b0;
    phys_addr_hi = cpu_addr_hi;
    unique case (mode)
      3'd0: use_b1 = 1'b0;
      3'd1: use_b1 = (cpu_addr_hi == 2'b11);
      3'd2: use_b1 = 1'b1;
      3'd3: begin
        use_b1 = (cpu_addr_hi == 2'b11);
        if (cpu_addr_hi == 2'b01) phys_addr_hi = 2'b11;
      end
      default: begin
        if (cpu_addr_hi == 2'b01) begin
          use_b1       = 1'b1;
          phys_addr_hi = mode[1:0];
        end
      end
    endcase
  end

  assign en          = !cas_n && !ram_off;
  assign bank0_cas_n = !(en && !use_b1);
  assign bank1_cas_n = !(en && use_b1);

endmodule

// File: rtl/ram_page_ctrl_chk.sv
module ram_page_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cpu_addr_hi,
  input logic [7:0] data_in,
  input logic       io_wr_n,
  input logic       cas_n,
  input logic       ram_off,
  input logic       bank0_cas_n,
  input logic       bank1_cas_n,
  input logic [1:0] phys_addr_hi,
  input logic [2:0] mode,
  input logic       wr_n_q
);

  assert_excl_strobes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bank0_cas_n && !bank1_cas_n));

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && !ram_off) |-> $countones({bank0_cas_n, bank1_cas_n}) == 1);

  assert_idle_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_off || cas_n) |-> (bank0_cas_n && bank1_cas_n));

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_wr_n && wr_n_q && cpu_addr_hi == 2'b01 && data_in[7] && data_in[6])
      |=> mode == $past(data_in[2:0]));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!io_wr_n && wr_n_q && cpu_addr_hi == 2'b01 && data_in[7] && data_in[6])
      |=> $stable(mode));

  assert_low_windows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_addr_hi[0]) |-> phys_addr_hi == cpu_addr_hi);

endmodule

bind ram_page_ctrl ram_page_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_addr_hi(cpu_addr_hi), .data_in(data_in),
  .io_wr_n(io_wr_n), .cas_n(cas_n), .ram_off(ram_off),
  .bank0_cas_n(bank0_cas_n), .bank1_cas_n(bank1_cas_n),
  .phys_addr_hi(phys_addr_hi), .mode(mode), .wr_n_q(wr_n_q)
);

// File: tb/ram_page_ctrl_tb_top.sv
module ram_page_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cpu_addr_hi = 2'b00;
  logic [7:0] data_in = 8'h00;
  logic       io_wr_n = 1'b1;
  logic       cas_n = 1'b1;
  logic       ram_off = 1'b0;
  logic       bank0_cas_n;
  logic       bank1_cas_n;
  logic [1:0] phys_addr_hi;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ram_page_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr_hi(cpu_addr_hi), .data_in(data_in),
    .io_wr_n(io_wr_n), .cas_n(cas_n), .ram_off(ram_off),
    .bank0_cas_n(bank0_cas_n), .bank1_cas_n(bank1_cas_n),
    .phys_addr_hi(phys_addr_hi)
  );

  // expected {bank1, phys[1:0]} from the requirement text
  function automatic logic [2:0] expect_map(input int m, input logic [1:0] w);
    if (m == 0) return {1'b0, w};
    if (m == 1) return {w == 2'b11, w};
    if (m == 2) return {1'b1, w};
    if (m == 3) return (w == 2'b01) ? 3'b011 : {w == 2'b11, w};
    return (w == 2'b01) ? {1'b1, m[1:0]} : {1'b0, w};
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic write_io(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr_hi = a; data_in = d; io_wr_n = 1'b0;
    @(negedge clk);
    io_wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic probe(input string req, input int m, input logic [1:0] w);
    logic [2:0] e;
    @(negedge clk);
    cpu_addr_hi = w; cas_n = 1'b0; ram_off = 1'b0;
    #1;
    e = expect_map(m, w);
    check(req, {bank0_cas_n, bank1_cas_n, phys_addr_hi},
          {e[2], ~e[2], e[1:0]});
    cas_n = 1'b1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    #1;
    check("R1 reset strobes idle", {bank0_cas_n, bank1_cas_n, 2'b00}, 4'b1100);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int w = 0; w < 4; w++) probe("R1 reset map", 0, w[1:0]);
  endtask

  task automatic t_modes;
    for (int m = 0; m < 8; m++) begin
      write_io(2'b01, 8'hC0 | m[7:0]);
      for (int w = 0; w < 4; w++) begin
        if (m <= 2)      probe("R5 R6 R9 low modes", m, w[1:0]);
        else if (m == 3) probe("R7 R9 mode3", m, w[1:0]);
        else             probe("R8 R9 high modes", m, w[1:0]);
      end
    end
  endtask

  task automatic t_reject;
    write_io(2'b01, 8'hC2);
    write_io(2'b00, 8'hC0);
    probe("R3 wrong address ignored", 2, 2'b00);
    write_io(2'b11, 8'hC0);
    probe("R3 wrong address ignored", 2, 2'b00);
    write_io(2'b01, 8'h80);
    probe("R3 D6 low ignored", 2, 2'b10);
    write_io(2'b01, 8'h40);
    probe("R3 D7 low ignored", 2, 2'b01);
  endtask

  task automatic t_hold_low;
    @(negedge clk);
    cpu_addr_hi = 2'b01; data_in = 8'hC5; io_wr_n = 1'b0;
    @(negedge clk);
    data_in = 8'hC7;
    repeat (3) @(negedge clk);
    io_wr_n = 1'b1;
    probe("R4 held strobe loads once", 5, 2'b01);
  endtask

  task automatic t_disable;
    write_io(2'b01, 8'hC2);
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      cpu_addr_hi = w[1:0]; cas_n = 1'b0; ram_off = 1'b1;
      #1;
      check("R11 ram_off idles strobes", {bank0_cas_n, bank1_cas_n, 2'b00}, 4'b1100);
      cas_n = 1'b1; ram_off = 1'b0;
      #1;
      check("R11 cas_n high idles strobes", {bank0_cas_n, bank1_cas_n, 2'b00}, 4'b1100);
    end
  endtask

  task automatic t_same_cycle;
    logic [2:0] e;
    write_io(2'b01, 8'hC0);
    @(negedge clk);
    cpu_addr_hi = 2'b01; cas_n = 1'b0; data_in = 8'hC6; io_wr_n = 1'b0;
    #1;
    e = expect_map(0, 2'b01);
    check("R10 before loading edge", {bank0_cas_n, bank1_cas_n, phys_addr_hi},
          {e[2], ~e[2], e[1:0]});
    @(negedge clk);
    e = expect_map(6, 2'b01);
    check("R10 R2 after loading edge", {bank0_cas_n, bank1_cas_n, phys_addr_hi},
          {e[2], ~e[2], e[1:0]});
    io_wr_n = 1'b1; cas_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_modes();
    t_reject();
    t_hold_low();
    t_disable();
    t_same_cycle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule